// File: doc/BRIEF.md
# Two-Level Adaptive Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It does not index its counter table by branch address. It keeps a short shift register of recent taken/not-taken outcomes and uses that value to pick a 2-bit saturating counter. The counter's upper bit is the guess. A lookup port takes a branch address and returns the guess in the same cycle, with no register in the path. A resolve port takes a branch address and the real outcome. At the next clock edge it adjusts the chosen counter and then shifts the outcome into the history.

An elaboration parameter picks how the state is shared:

- **Global:** one outcome history serves every branch, and one counter table serves every branch.
- **Local-shared:** each recently seen branch has its own history, and all of them share one counter table.
- **Local-private:** each recently seen branch has its own history and its own counter table.

Per-branch history lives in a small direct-mapped set of slots. The low address bits pick the slot and a tag of the upper bits names the owner. A branch that finds its slot owned by another branch starts from an empty history and takes the slot over.

Top module: `twolevel_dir_pred`

## Requirements
- R1: A resolve shifts the outcome (1 = taken, 0 = not taken) into bit 0 of the selected history. The older bits move up one place and the most significant bit is discarded.
- R2: In the global and local-shared organisations, the counter index is the history value. In the local-private organisation, the index is {slot, history}, so each slot owns 2^HIST_W counters.
- R3: A counter counts up on a taken outcome and down on a not-taken outcome. It stays at 3 when counted up at 3 and stays at 0 when counted down at 0.
- R4: On a resolve, the counter chosen by the history value held before that resolve is updated. The history shifts in the same clock edge, so the next lookup sees both changes.
- R5: The prediction is bit 1 of the chosen counter: values 2 and 3 predict taken, values 0 and 1 predict not taken.
- R6: After a synchronous active-low reset, every counter holds 1, every history holds 0 and no slot has an owner, so every lookup predicts not taken.
- R7: In the global organisation, one history is shared by all branch addresses, and a resolve of any address shifts it.
- R8: In the local-shared organisation, each slot keeps its own history, and resolves of branches in different slots leave each other's history untouched.
- R9: In the local-private organisation, a counter changed by a branch in one slot never changes the prediction of a branch in another slot.
- R10: The slot is address bits [SLOT_W+1:2] and the tag is the bits above them. A lookup whose tag differs from the slot owner's uses history 0. A resolve whose tag differs uses history 0, makes that address the owner, and leaves the slot's private counters unchanged.
- R11: A lookup and a resolve in the same cycle are allowed. The lookup sees the state from before that resolve.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | ADDR_W | Address of the branch being predicted |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken (combinational) |
| rs_valid | input | 1 | A branch outcome is presented this cycle |
| rs_pc | input | ADDR_W | Address of the resolved branch |
| rs_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
The embedded properties assume that rs_valid is low while reset is held and is never unknown afterwards. They also assume that rs_pc and rs_taken are stable across each rising edge at which rs_valid is high. The stimulus meets these conditions in three ways: it holds every input low through reset, it changes inputs only at the falling edge, and it draws addresses from a fixed set.

That address set is chosen so that several branches fall into the same slot with different tags. This drives the slot-takeover path repeatedly. Long runs of one outcome then push the counters into both saturation limits in all three organisations.

// File: rtl/tlp_pkg.sv
// Package for the two-level predictor: the organisation selector, the counter
// type and the saturating counter step. Assumes nothing about its users.
package tlp_pkg;

    typedef enum logic [1:0] {
        ORG_GLOBAL        = 2'd0,
        ORG_LOCAL_SHARED  = 2'd1,
        ORG_LOCAL_PRIVATE = 2'd2
    } tlp_org_e;

    typedef logic [1:0] ctr2_t;

    localparam ctr2_t CTR_INIT = 2'd1;
    localparam ctr2_t CTR_MAX  = 2'd3;
    localparam ctr2_t CTR_MIN  = 2'd0;

    // Next counter value from the previous value and the real outcome.
    function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
        ctr2_t nxt;
        if (taken)
            nxt = (cur == CTR_MAX) ? CTR_MAX : cur + 2'd1;
        else
            nxt = (cur == CTR_MIN) ? CTR_MIN : cur - 2'd1;
        return nxt;
    endfunction

endpackage

// File: rtl/tlp_hist_file.sv
// Outcome history storage. With SHARED_HIST set it holds one register used by
// every address. Otherwise it holds a direct-mapped set of NUM_SLOTS tagged
// registers, where a tag miss reads as an empty history.
// Assumes HIST_W >= 2, NUM_SLOTS a power of two >= 2, and address bits [1:0]
// not significant for branch identity.
module tlp_hist_file #(
    parameter int ADDR_W      = 32,
    parameter int HIST_W      = 4,
    parameter int NUM_SLOTS   = 4,
    parameter bit SHARED_HIST = 1'b0,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int TAG_W      = ADDR_W - SLOT_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic [HIST_W-1:0] lk_hist,
    output logic [SLOT_W-1:0] lk_slot,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken,
    output logic [HIST_W-1:0] rs_hist,
    output logic [SLOT_W-1:0] rs_slot
);

    logic [TAG_W-1:0] lk_tag, rs_tag;

    // Split both addresses into slot and tag fields.
    always_comb begin
        lk_slot = lk_pc[SLOT_W+1:2];
        lk_tag  = lk_pc[ADDR_W-1:SLOT_W+2];
        rs_slot = rs_pc[SLOT_W+1:2];
        rs_tag  = rs_pc[ADDR_W-1:SLOT_W+2];
    end

    generate
        if (SHARED_HIST) begin : g_global
            logic [HIST_W-1:0] ghist_q;

            // Both ports read the single shared history.
            always_comb begin
                lk_hist = ghist_q;
                rs_hist = ghist_q;
            end

            // Shift each resolved outcome into the shared history.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ghist_q <= '0;
                else if (rs_valid)
                    ghist_q <= {ghist_q[HIST_W-2:0], rs_taken};
            end

            // R1
            gshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rs_valid |=> (ghist_q[0] == $past(rs_taken)) &&
                             (ghist_q[HIST_W-1:1] == $past(rs_hist[HIST_W-2:0])));
        end else begin : g_local
            logic [HIST_W-1:0] hist_q [NUM_SLOTS];
            logic [TAG_W-1:0]  tag_q  [NUM_SLOTS];
            logic [NUM_SLOTS-1:0] own_q;
            logic lk_hit, rs_hit;

            // A slot owned by another address reads as an empty history.
            always_comb begin
                lk_hit  = own_q[lk_slot] && (tag_q[lk_slot] == lk_tag);
                rs_hit  = own_q[rs_slot] && (tag_q[rs_slot] == rs_tag);
                lk_hist = lk_hit ? hist_q[lk_slot] : '0;
                rs_hist = rs_hit ? hist_q[rs_slot] : '0;
            end

            // Shift the outcome into the resolved slot and take ownership of it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    own_q <= '0;
                    for (int s = 0; s < NUM_SLOTS; s++) begin
                        hist_q[s] <= '0;
                        tag_q[s]  <= '0;
                    end
                end else if (rs_valid) begin
                    hist_q[rs_slot] <= {rs_hist[HIST_W-2:0], rs_taken};
                    tag_q[rs_slot]  <= rs_tag;
                    own_q[rs_slot]  <= 1'b1;
                end
            end

            // R1
            lshift_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rs_valid |=> (hist_q[$past(rs_slot)][0] == $past(rs_taken)) &&
                             (hist_q[$past(rs_slot)][HIST_W-1:1] == $past(rs_hist[HIST_W-2:0])));
            // R10
            owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                rs_valid |=> own_q[$past(rs_slot)] && (tag_q[$past(rs_slot)] == $past(rs_tag)));
            // R8
            other_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rs_valid && (rs_slot != lk_slot)) |=> (hist_q[$past(lk_slot)] == $past(hist_q[lk_slot])));
        end
    endgenerate

endmodule

// File: rtl/tlp_pattern_table.sv
// Table of 2-bit saturating counters with one combinational read port and one
// clocked update port. Assumes the update index is stable across the edge.
module tlp_pattern_table #(
    parameter int IDX_W  = 4,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output tlp_pkg::ctr2_t    rd_ctr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken
);
    import tlp_pkg::*;

    ctr2_t ctr_q [DEPTH];

    // Read the counter picked by the lookup index.
    always_comb rd_ctr = ctr_q[rd_idx];

    // Initialise to weakly not taken; step the selected counter on update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                ctr_q[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr_q[wr_idx] <= ctr_step(ctr_q[wr_idx], wr_taken);
        end
    end

    // R3
    sat_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] == CTR_MAX) |=> ctr_q[$past(wr_idx)] == CTR_MAX);
    // R3
    sat_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_MIN) |=> ctr_q[$past(wr_idx)] == CTR_MIN);
    // R3
    step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && ctr_q[wr_idx] != CTR_MAX) |=>
            ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) + 2'd1);
    // R3
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && ctr_q[wr_idx] != CTR_MIN) |=>
            ctr_q[$past(wr_idx)] == $past(ctr_q[wr_idx]) - 2'd1);
    // R9
    untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_idx != rd_idx) |=> ctr_q[$past(rd_idx)] == $past(rd_ctr));

endmodule

// File: rtl/twolevel_dir_pred.sv
// Two-level adaptive branch direction predictor. Outcome history picks a
// 2-bit counter, and the counter's upper bit is the guess. ORG chooses
// global/shared/private sharing of history and counters.
// Assumes one resolve per cycle and at most one lookup per cycle.
module twolevel_dir_pred #(
    parameter int               ADDR_W    = 32,
    parameter int               HIST_W    = 4,
    parameter int               NUM_SLOTS = 4,
    parameter tlp_pkg::tlp_org_e ORG      = tlp_pkg::ORG_LOCAL_PRIVATE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_pc,
    output logic              lk_taken,
    input  logic              rs_valid,
    input  logic [ADDR_W-1:0] rs_pc,
    input  logic              rs_taken
);
    import tlp_pkg::*;

    localparam int SLOT_W  = $clog2(NUM_SLOTS);
    localparam bit SHARED  = (ORG == ORG_GLOBAL);
    localparam bit PRIVATE = (ORG == ORG_LOCAL_PRIVATE);
    localparam int IDX_W   = HIST_W + (PRIVATE ? SLOT_W : 0);

    logic [HIST_W-1:0] lk_hist, rs_hist;
    logic [SLOT_W-1:0] lk_slot, rs_slot;
    logic [IDX_W-1:0]  lk_idx, rs_idx;
    ctr2_t             lk_ctr;

    tlp_hist_file #(
        .ADDR_W(ADDR_W), .HIST_W(HIST_W), .NUM_SLOTS(NUM_SLOTS), .SHARED_HIST(SHARED)
    ) u_hist (
        .clk(clk), .rst_n(rst_n),
        .lk_pc(lk_pc), .lk_hist(lk_hist), .lk_slot(lk_slot),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken),
        .rs_hist(rs_hist), .rs_slot(rs_slot)
    );

    generate
        if (PRIVATE) begin : g_priv_idx
            // Prefix the history with the slot so each slot owns a table.
            always_comb begin
                lk_idx = {lk_slot, lk_hist};
                rs_idx = {rs_slot, rs_hist};
            end
        end else begin : g_shared_idx
            // History alone indexes the shared table.
            always_comb begin
                lk_idx = lk_hist;
                rs_idx = rs_hist;
            end
        end
    endgenerate

    tlp_pattern_table #(.IDX_W(IDX_W)) u_pt (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(lk_idx), .rd_ctr(lk_ctr),
        .wr_en(rs_valid), .wr_idx(rs_idx), .wr_taken(rs_taken)
    );

    // Guess taken for counter values 2 and 3.
    always_comb lk_taken = lk_ctr[1];

    // R11
    same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rs_valid |=> (lk_pc != $past(lk_pc)) || (lk_taken == $past(lk_taken)));

endmodule

// File: tb/test_twolevel_dir_pred.sv
// Bench: three predictor instances, one per organisation, all driven with the
// same stimulus. A behavioural model built on plain integer arrays is compared
// with every prediction on every clock.
module test_twolevel_dir_pred;
    import tlp_pkg::*;

    localparam int AW = 32;
    localparam int HW = 4;
    localparam int NS = 4;
    localparam int HD = 1 << HW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] lk_pc = '0;
    logic [AW-1:0] rs_pc = '0;
    logic rs_valid = 1'b0;
    logic rs_taken = 1'b0;
    logic pred [3];

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    // Behavioural reference state, one set per organisation.
    int m_hist [3][NS];
    int m_tag  [3][NS];
    bit m_own  [3][NS];
    int m_ctr  [3][NS*HD];

    always #5 clk = ~clk;

    twolevel_dir_pred #(.ADDR_W(AW), .HIST_W(HW), .NUM_SLOTS(NS), .ORG(ORG_GLOBAL)) i_twolevel_dir_pred_glob (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred[0]),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));
    twolevel_dir_pred #(.ADDR_W(AW), .HIST_W(HW), .NUM_SLOTS(NS), .ORG(ORG_LOCAL_SHARED)) i_twolevel_dir_pred_shr (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred[1]),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));
    twolevel_dir_pred #(.ADDR_W(AW), .HIST_W(HW), .NUM_SLOTS(NS), .ORG(ORG_LOCAL_PRIVATE)) i_twolevel_dir_pred (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(pred[2]),
        .rs_valid(rs_valid), .rs_pc(rs_pc), .rs_taken(rs_taken));

    function automatic int slot_of(int unsigned pc);
        return int'((pc >> 2) % NS);
    endfunction

    function automatic int tag_of(int unsigned pc);
        return int'(pc >> 4);
    endfunction

    // History seen by an address: shared in org 0, empty on a tag miss (R10).
    function automatic int hist_of(int o, int unsigned pc);
        int s = slot_of(pc);
        if (o == 0) return m_hist[0][0];
        if (m_own[o][s] && m_tag[o][s] == tag_of(pc)) return m_hist[o][s];
        return 0;
    endfunction

    function automatic int idx_of(int o, int unsigned pc);
        if (o == 2) return slot_of(pc) * HD + hist_of(o, pc);
        return hist_of(o, pc);
    endfunction

    task automatic model_reset();
        for (int o = 0; o < 3; o++) begin
            for (int s = 0; s < NS; s++) begin
                m_hist[o][s] = 0; m_tag[o][s] = 0; m_own[o][s] = 1'b0;
            end
            for (int i = 0; i < NS*HD; i++) m_ctr[o][i] = 1;
        end
    endtask

    // Counter first at the old history (R4), then the shift (R1).
    task automatic model_resolve(int o, int unsigned pc, bit t);
        int i = idx_of(o, pc);
        int h = hist_of(o, pc);
        int s = (o == 0) ? 0 : slot_of(pc);
        if (t) m_ctr[o][i] = (m_ctr[o][i] == 3) ? 3 : m_ctr[o][i] + 1;
        else   m_ctr[o][i] = (m_ctr[o][i] == 0) ? 0 : m_ctr[o][i] - 1;
        m_hist[o][s] = ((h << 1) | int'(t)) % HD;
        m_tag[o][s]  = tag_of(pc);
        m_own[o][s]  = 1'b1;
    endtask

    // One cycle: drive at the falling edge, compare 1 ns later, then advance the model.
    task automatic step(int unsigned lpc, bit rv, int unsigned rpc, bit rt, string req);
        @(negedge clk);
        lk_pc = lpc; rs_valid = rv; rs_pc = rpc; rs_taken = rt;
        #1;
        for (int o = 0; o < 3; o++) begin
            bit exp_t = (m_ctr[o][idx_of(o, lpc)] >= 2);   // R5
            n_checks++;
            if (pred[o] !== exp_t) begin
                n_fails++;
                $display("FAIL %s org=%0d pc=%h actual=%b expected=%b", req, o, lpc, pred[o], exp_t);
            end
        end
        if (rv) for (int o = 0; o < 3; o++) model_resolve(o, rpc, rt);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        int unsigned pcs [8] = '{32'h100, 32'h104, 32'h108, 32'h10C, 32'h114, 32'h200, 32'h204, 32'h31C};
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R6: everything predicts not taken after reset.
        for (int k = 0; k < 8; k++) step(pcs[k], 1'b0, 0, 1'b0, "R6");

        // R1 R4 R5: one loop branch repeatedly taken, probed every cycle.
        for (int k = 0; k < 12; k++) step(32'h100, 1'b1, 32'h100, 1'b1, "R1_R4_R5");
        // R3: saturate high, then walk down to and hold at zero.
        for (int k = 0; k < 6; k++) step(32'h100, 1'b1, 32'h100, 1'b1, "R3");
        for (int k = 0; k < 14; k++) step(32'h100, 1'b1, 32'h100, 1'b0, "R3");

        // R10: two addresses sharing slot 1 with different tags.
        for (int k = 0; k < 16; k++)
            step((k % 2) ? 32'h114 : 32'h104, 1'b1, (k % 3) ? 32'h104 : 32'h114, k[0], "R10");

        // R11: lookup of the address being resolved in the same cycle.
        for (int k = 0; k < 10; k++) step(32'h108, 1'b1, 32'h108, (k % 4) != 3, "R11");

        // R2 R7 R8 R9: mixed traffic with per-address loop periods.
        for (int k = 0; k < 3000; k++) begin
            int a = (k * 5 + k / 7) % 8;
            int b = (k * 3 + 1) % 8;
            bit t = ((k / 8) % (b + 2)) != 0;
            if ((k % 97) == 0) t = ~t;
            step(pcs[a], (k % 5) != 4, pcs[b], t, "R2_R7_R8_R9");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule